// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table that lives in memory. Pages are 4 KB, so the low 12 address bits pass through untouched. The remaining 20 bits form the virtual page number. Its upper 10 bits select an entry in a first-level table. Its lower 10 bits select an entry in the second-level table that the first entry points to. Every entry is one 4-byte word.

A client presents a virtual address and the base of the first-level table, and pulses a start strobe. The walker then issues one or two reads on a single request/response read port. It reports either the translated address or a fault. A first-level entry with its valid bit clear ends the walk after one read, because the whole 4 MB region behind it is unmapped. No entries are cached and no permissions are checked.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and after its release, busy_o, done_o and mem_req_o are 0.
- R2: A start_i seen while the walker is idle makes busy_o and mem_req_o 1 in the next cycle, with mem_addr_o = root_i + 4 × va_i[31:22].
- R3: When the first read returns a word with bit 0 set, the second read is issued at {word[31:12], 12'h000} + 4 × va[21:12]; word bits 11:1 have no effect on that address.
- R4: When the second read returns a word with bit 0 set, done_o pulses with fault_o = 0, fault_l1_o = 0 and pa_o = {word[31:12], va[11:0]}.
- R5: When the first read returns a word with bit 0 clear, the walk makes exactly one read and ends with done_o, fault_o = 1 and fault_l1_o = 1.
- R6: When the second read returns a word with bit 0 clear, the walk ends after two reads with fault_o = 1 and fault_l1_o = 0.
- R7: start_i while busy_o is 1 is ignored: a different va_i or root_i presented then changes neither the read addresses nor the result of the walk in progress.
- R8: done_o is high for exactly one cycle per walk, busy_o is 0 in that cycle, and a start_i in that same cycle begins a new walk.
- R9: mem_req_o, once raised, stays high with an unchanged mem_addr_o until mem_rvalid_i arrives, for any response latency.
- R10: mem_req_o is only raised while busy_o is 1, and at most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| va_i | input | 32 | Virtual address to translate |
| root_i | input | 32 | Byte address of the first-level table |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 1 | Translation failed |
| fault_l1_o | output | 1 | Failure came from the first-level entry |
| pa_o | output | 32 | Physical address (valid with done_o when fault_o is 0) |
| mem_req_o | output | 1 | Read request, held until the response |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response word |

## Verification
The two functions that can share a cycle are the completion strobe of one walk and the acceptance of the next start. The bench waits until it sees done_o. In that same cycle it raises start_i with a new address. It then requires busy_o and the new first-level address one cycle later, and the correct translation for the second walk. A second overlap comes from a start_i held high with a changed address while a walk runs. That walk is judged by the addresses it reads and the result it reports, both of which must belong to the first request.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2
  } walk_st_e;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int PTE_SH = 2
) (
  input  logic [ADDR_W-1:0]       va_i,
  input  logic [ADDR_W-1:0]       root_i,
  input  logic [ADDR_W-OFF_W-1:0] l2_base_i,
  input  logic                    sel_l2_i,
  output logic [ADDR_W-1:0]       addr_o
);
  logic [IDX_W-1:0]  l1_idx, l2_idx;
  logic [ADDR_W-1:0] l1_addr, l2_addr;

  assign l1_idx  = va_i[ADDR_W-1 -: IDX_W];
  assign l2_idx  = va_i[OFF_W +: IDX_W];
  assign l1_addr = root_i + (ADDR_W'(l1_idx) << PTE_SH);
  assign l2_addr = {l2_base_i, {OFF_W{1'b0}}} + (ADDR_W'(l2_idx) << PTE_SH);
  assign addr_o  = sel_l2_i ? l2_addr : l1_addr;
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [ADDR_W-1:0]       va_i,
  input  logic [ADDR_W-1:0]       root_i,
  input  logic                    mem_rvalid_i,
  input  logic [ADDR_W-1:0]       mem_rdata_i,
  output logic [ADDR_W-1:0]       va_o,
  output logic [ADDR_W-1:0]       root_o,
  output logic [ADDR_W-OFF_W-1:0] l2_base_o,
  output logic                    sel_l2_o,
  output logic                    mem_req_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    fault_o,
  output logic                    fault_l1_o,
  output logic [ADDR_W-1:0]       pa_o
);
  walk_st_e                st_q;
  logic [ADDR_W-1:0]       va_q, root_q, pa_q;
  logic [ADDR_W-OFF_W-1:0] base_q;
  logic                    done_q, fault_q, fl1_q;
  logic                    pte_valid;
  logic                    rdata_unused;

  assign pte_valid    = mem_rdata_i[0];
  assign rdata_unused = ^mem_rdata_i[OFF_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      root_q  <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      fl1_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          va_q   <= va_i;
          root_q <= root_i;
          st_q   <= ST_RD1;
        end
        ST_RD1: if (mem_rvalid_i) begin
          if (pte_valid) begin
            base_q <= mem_rdata_i[ADDR_W-1:OFF_W];
            st_q   <= ST_RD2;
          end else begin
            // null first-level entry: region unmapped, stop here
            st_q    <= ST_IDLE;
            done_q  <= 1'b1;
            fault_q <= 1'b1;
            fl1_q   <= 1'b1;
          end
        end
        ST_RD2: if (mem_rvalid_i) begin
          st_q    <= ST_IDLE;
          done_q  <= 1'b1;
          fault_q <= ~pte_valid;
          fl1_q   <= 1'b0;
          pa_q    <= {mem_rdata_i[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign va_o       = va_q;
  assign root_o     = root_q;
  assign l2_base_o  = base_q;
  assign sel_l2_o   = (st_q == ST_RD2);
  assign mem_req_o  = (st_q == ST_RD1) || (st_q == ST_RD2);
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign fault_o    = fault_q;
  assign fault_l1_o = fl1_q;
  assign pa_o       = pa_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [ADDR_W-1:0] root_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              fault_l1_o,
  output logic [ADDR_W-1:0] pa_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i
);
  localparam int VPN_W  = ADDR_W - OFF_W;
  localparam int PTE_SH = 2;

  logic [ADDR_W-1:0] va_q, root_q;
  logic [VPN_W-1:0]  l2_base;
  logic              sel_l2;

  pt_walk_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .va_i        (va_i),
    .root_i      (root_i),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .va_o        (va_q),
    .root_o      (root_q),
    .l2_base_o   (l2_base),
    .sel_l2_o    (sel_l2),
    .mem_req_o   (mem_req_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .fault_l1_o  (fault_l1_o),
    .pa_o        (pa_o)
  );

  pt_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_SH(PTE_SH)) u_addr (
    .va_i     (va_q),
    .root_i   (root_q),
    .l2_base_i(l2_base),
    .sel_l2_i (sel_l2),
    .addr_o   (mem_addr_o)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              fault_o,
  input logic              fault_l1_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i
);
  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && mem_req_o);

  p_l1_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_l1_o |-> fault_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  p_req_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .fault_l1_o  (fault_l1_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  localparam int NVEC = 6;

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] root;
    logic        flt;
    logic        fl1;
    logic [31:0] pa;
    logic [3:0]  lat;
  } vec_t;

  // mem word index = addr[12:2]; root 0x000 or 0x800, second-level table at 0x1000
  localparam vec_t VEC [NVEC] = '{
    '{32'h0000_0123, 32'h0000_0000, 1'b0, 1'b0, 32'hABCD_E123, 4'd0},
    '{32'h0140_0456, 32'h0000_0000, 1'b1, 1'b1, 32'h0,         4'd1},
    '{32'h0000_7FFF, 32'h0000_0000, 1'b1, 1'b0, 32'h0,         4'd3},
    '{32'h00FF_F000, 32'h0000_0000, 1'b0, 1'b0, 32'hFFFF_F000, 4'd0},
    '{32'h0080_2ABC, 32'h0000_0800, 1'b0, 1'b0, 32'h0BEE_FABC, 4'd2},
    '{32'hFFC0_0000, 32'h0000_0000, 1'b1, 1'b1, 32'h0,         4'd5}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] va_i = '0, root_i = '0;
  logic        busy_o, done_o, fault_o, fault_l1_o, mem_req_o;
  logic [31:0] pa_o, mem_addr_o;
  logic        mem_rvalid_i;
  logic [31:0] mem_rdata_i;

  logic [31:0] mem [2048];
  logic [3:0]  lat_r = '0;
  logic [3:0]  wcnt;
  logic [31:0] rd_cnt;
  logic [31:0] addr_hist [8];

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  pt_walker dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .va_i(va_i), .root_i(root_i),
    .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .fault_l1_o(fault_l1_o),
    .pa_o(pa_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  // memory model: answers a held request after lat_r extra cycles
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_rvalid_i <= 1'b0;
      mem_rdata_i  <= '0;
      wcnt         <= '0;
      rd_cnt       <= '0;
    end else if (mem_rvalid_i) begin
      mem_rvalid_i <= 1'b0;
      wcnt         <= '0;
    end else if (mem_req_o) begin
      if (wcnt >= lat_r) begin
        mem_rvalid_i           <= 1'b1;
        mem_rdata_i            <= mem[mem_addr_o[12:2]];
        addr_hist[rd_cnt[2:0]] <= mem_addr_o;
        rd_cnt                 <= rd_cnt + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] l1_addr(input logic [31:0] va, input logic [31:0] root);
    return root + {20'b0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] l2_addr(input logic [31:0] va, input logic [31:0] root);
    logic [31:0] e;
    e = mem[l1_addr(va, root) >> 2];
    return {e[31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
  endfunction

  task automatic wait_done();
    bit seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk_i);
      if (done_o) seen = 1;
    end
    chk(seen, "R8 done seen", 32'(seen), 32'd1);
  endtask

  task automatic check_result(input vec_t v, input logic [31:0] rc0, input string tag);
    logic [31:0] nrd;
    nrd = rd_cnt - rc0;
    chk(fault_o == v.flt, {tag, " R4/R6 fault"}, 32'(fault_o), 32'(v.flt));
    chk(fault_l1_o == v.fl1, {tag, " R5 fault_l1"}, 32'(fault_l1_o), 32'(v.fl1));
    chk(nrd == (v.fl1 ? 32'd1 : 32'd2), {tag, " R5 read count"}, nrd, v.fl1 ? 32'd1 : 32'd2);
    chk(addr_hist[rc0[2:0]] == l1_addr(v.va, v.root), {tag, " R2 first addr"},
        addr_hist[rc0[2:0]], l1_addr(v.va, v.root));
    if (!v.fl1) begin
      logic [31:0] i2;
      i2 = rc0 + 1;
      chk(addr_hist[i2[2:0]] == l2_addr(v.va, v.root), {tag, " R3 second addr"},
          addr_hist[i2[2:0]], l2_addr(v.va, v.root));
    end
    if (!v.flt) chk(pa_o == v.pa, {tag, " R4 pa"}, pa_o, v.pa);
    chk(!busy_o, {tag, " R8 idle at done"}, 32'(busy_o), 32'd0);
  endtask

  // called at a negedge; leaves start low one cycle later
  task automatic launch(input vec_t v);
    start_i = 1'b1;
    va_i    = v.va;
    root_i  = v.root;
    lat_r   = v.lat;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o && mem_req_o, "R2 busy and req after start", {30'b0, busy_o, mem_req_o}, 32'd3);
    chk(mem_addr_o == l1_addr(v.va, v.root), "R2 first addr", mem_addr_o, l1_addr(v.va, v.root));
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL R10 watchdog expired act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rc0;
    vec_t v;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    mem[0]    = 32'h0000_1001;
    mem[3]    = 32'h0000_1FFF;   // low bits 11:1 set, R3 must ignore them
    mem[514]  = 32'h0000_1001;
    mem[1024] = 32'hABCD_E001;
    mem[1031] = 32'h1234_5000;   // second-level entry invalid
    mem[1026] = 32'h0BEE_F001;
    mem[2047] = 32'hFFFF_F003;

    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o, "R1 in reset", {29'b0, busy_o, done_o, mem_req_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o, "R1 after reset", {29'b0, busy_o, done_o, mem_req_o}, 32'd0);

    // vector table, latencies vary for R9
    for (int k = 0; k < NVEC; k++) begin
      v   = VEC[k];
      rc0 = rd_cnt;
      launch(v);
      wait_done();
      check_result(v, rc0, $sformatf("vec%0d", k));
      @(negedge clk_i);
      chk(!done_o, "R8 done one cycle", 32'(done_o), 32'd0);
    end

    // R7: start held with a different address while busy
    v   = VEC[0];
    v.lat = 4'd3;
    rc0 = rd_cnt;
    launch(v);
    start_i = 1'b1;
    va_i    = VEC[3].va;
    root_i  = 32'h0000_0800;
    repeat (3) @(negedge clk_i);
    start_i = 1'b0;
    wait_done();
    check_result(v, rc0, "r7_busy_start");
    @(negedge clk_i);
    chk(!busy_o, "R7 no extra walk", 32'(busy_o), 32'd0);

    // R8: next start in the done cycle (done and accept coincide)
    v   = VEC[2];
    rc0 = rd_cnt;
    launch(v);
    wait_done();
    check_result(v, rc0, "r8_first");
    v   = VEC[4];
    rc0 = rd_cnt;
    launch(v);
    wait_done();
    check_result(v, rc0, "r8_second");

    repeat (3) @(negedge clk_i);
    chk(!mem_req_o && !busy_o, "R10 quiet when idle", {30'b0, busy_o, mem_req_o}, 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule